// File: doc/BRIEF.md
# Reloading Down-Counter Toggle Timer

This block is one channel of a 16-bit timer that produces a free-running square wave. Software writes a starting count and a reload value, then enables the channel, either by a register write or by a one-cycle trigger pulse from a neighbouring timer. Once enabled, the channel acts only on prescaler ticks. The first tick after the enable takes effect inverts the output flip-flop. After that the counter steps down once per tick. When it passes zero it underflows. At that point the output inverts again, a one-cycle interrupt pulse is raised, and counting resumes from the reload register.

On the underflow tick the counter reads back as all ones. On the following tick it reads reload minus one, so every period after the first lasts reload + 1 ticks. The first period, measured from the start tick, lasts the written count + 1 ticks. Only a software disable stops the channel. When the channel is stopped, the flip-flop keeps its level.

Top module: `reload_toggle_timer`

## Requirements
- R1: After reset the counter reads 0, the flip-flop output is low, the interrupt is low and the channel is stopped.
- R2: Writing the enable bit with value 1, or pulsing the external trigger, starts a stopped channel. The flip-flop inverts on the first tick seen in a cycle after the start request, and the counter is not decremented on that tick. A tick in the same cycle as the request does nothing.
- R3: While running, the counter decreases by exactly one per tick. Between ticks it does not change.
- R4: Starting from a written count N, the underflow happens on the (N+1)-th tick after the start tick. On that tick the counter reads all ones (16'hFFFF at the default width).
- R5: On the tick after an underflow, the counter reads reload minus one, which gives reload + 1 ticks per period. With reload 0, every tick underflows and the counter stays all ones.
- R6: Every underflow inverts the flip-flop and raises the interrupt for exactly one system clock, in the cycle in which the all-ones value first appears.
- R7: Writing the enable bit with value 0 stops the channel. Further ticks leave the counter and the flip-flop unchanged, and no interrupt is raised. A disable write wins over a trigger pulse in the same cycle.
- R8: A counter write loads the counter only while the channel is stopped. While the channel is running, a counter write is ignored.
- R9: The reload register may be written at any time. The new value is used from the next underflow on. A period already under way finishes with the old value.
- R10: Enable writes or trigger pulses while the channel is running have no effect: there is no extra flip-flop inversion and no restart of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock tick from the prescaler, one cycle wide |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | W | Reload register write value |
| en_wr | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit value: 1 starts, 0 stops |
| ext_start | input | 1 | External start trigger pulse |
| cnt_rd | output | W | Counter readback |
| ff_out | output | 1 | Toggle flip-flop output |
| irq | output | 1 | Underflow interrupt pulse |

## Verification
The assertions check the following on every cycle:
- An interrupt appears only together with the all-ones readback and a flip-flop inversion.
- The counter never moves in a cycle after one with neither a tick nor a write.
- The flip-flop holds while the channel is stopped.
- A disable write leaves the channel stopped with no interrupt.

Other properties need the bench's scenarios, because they depend on counting ticks across whole periods:
- the period lengths of count + 1 and reload + 1;
- the reload-minus-one value after the all-ones state;
- the deferred use of a new reload value;
- the absence of a toggle on a tick that coincides with the enable;
- that writes and enables are ignored while running.

The bench sweeps small start and reload values, including zero.

// File: rtl/reload_toggle_timer.sv
module reload_toggle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_wdata,
  input  logic         en_wr,
  input  logic         en_wdata,
  input  logic         ext_start,
  output logic [W-1:0] cnt_rd,
  output logic         ff_out,
  output logic         irq
);

  logic [W-1:0] cnt_q, rld_q, shadow_q;
  logic         run_q, arm_q, wrap_q, ff_q, irq_q;

  wire sw_off    = en_wr & ~en_wdata;
  wire start_req = (en_wr & en_wdata) | ext_start;
  wire step      = run_q & tick & ~sw_off;
  wire at_end    = wrap_q ? (shadow_q == '0) : (cnt_q == '0);
  wire fire      = step & ~arm_q & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rld_q    <= '0;
      shadow_q <= '0;
      run_q    <= 1'b0;
      arm_q    <= 1'b0;
      wrap_q   <= 1'b0;
      ff_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= fire;
      if (rld_wr) rld_q <= rld_wdata;

      if (sw_off) begin
        run_q <= 1'b0;
        arm_q <= 1'b0;
      end else if (start_req && !run_q) begin
        run_q <= 1'b1;
        arm_q <= 1'b1;
      end

      if (cnt_wr && !run_q) begin
        cnt_q  <= cnt_wdata;
        wrap_q <= 1'b0;
      end else if (step) begin
        if (arm_q) begin
          arm_q <= 1'b0;
          ff_q  <= ~ff_q;
        end else if (fire) begin
          cnt_q    <= '1;
          wrap_q   <= 1'b1;
          shadow_q <= rld_q;
          ff_q     <= ~ff_q;
        end else if (wrap_q) begin
          cnt_q  <= shadow_q - 1'b1;
          wrap_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_rd = cnt_q;
  assign ff_out = ff_q;
  assign irq    = irq_q;

endmodule

// File: rtl/reload_toggle_timer_checks.sv
module reload_toggle_timer_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_wr,
  input logic         en_wr,
  input logic         en_wdata,
  input logic         run,
  input logic [W-1:0] cnt_rd,
  input logic         ff_out,
  input logic         irq
);

  assert_irq_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_rd == {W{1'b1}}));

  assert_irq_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ff_out != $past(ff_out)));

  assert_still_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_rd));

  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ff_out));

  assert_disable_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata) |=> (!run && !irq));

endmodule

bind reload_toggle_timer reload_toggle_timer_checks #(.W(W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .en_wr    (en_wr),
  .en_wdata (en_wdata),
  .run      (run_q),
  .cnt_rd   (cnt_rd),
  .ff_out   (ff_out),
  .irq      (irq)
);

// File: tb/test_reload_toggle_timer.sv
`timescale 1ns/1ps
module test_reload_toggle_timer;
  localparam int W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, cnt_wr = 1'b0, rld_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, ext_start = 1'b0;
  logic [W-1:0] cnt_wdata = '0, rld_wdata = '0;
  logic [W-1:0] cnt_rd;
  logic ff_out, irq;

  int checks = 0;
  int fails = 0;
  bit exp_ff = 1'b0;

  always #2.5 clk = ~clk;

  reload_toggle_timer #(.W(W)) i_reload_toggle_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .ext_start(ext_start),
    .cnt_rd(cnt_rd), .ff_out(ff_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick1();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic swen(input bit v);
    en_wr = 1'b1; en_wdata = v; @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wcnt(input logic [W-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wrld(input logic [W-1:0] v);
    rld_wr = 1'b1; rld_wdata = v; @(negedge clk); rld_wr = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_start = 1'b1; @(negedge clk); ext_start = 1'b0;
  endtask

  task automatic expect_wrap(input string req);
    tick1();
    exp_ff = ~exp_ff;
    chk(req, cnt_rd, ONES);
    chk(req, irq, 1);
    chk(req, ff_out, exp_ff);
    idle();
    chk("R6 single pulse", irq, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R1 cnt", cnt_rd, 0);
    chk("R1 ff", ff_out, 0);
    chk("R1 irq", irq, 0);
    tick1();
    chk("R1 stopped", cnt_rd, 0);
    chk("R1 stopped ff", ff_out, 0);

    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        swen(1'b0);
        chk("R7 no irq", irq, 0);
        wcnt(W'(s));
        wrld(W'(r));
        chk("R8 load stopped", cnt_rd, s);
        swen(1'b1);
        chk("R2 no toggle yet", ff_out, exp_ff);
        idle();
        chk("R2 wait tick", ff_out, exp_ff);
        tick1();
        exp_ff = ~exp_ff;
        chk("R2 start toggle", ff_out, exp_ff);
        chk("R2 no decrement", cnt_rd, s);
        for (int k = 1; k <= s; k++) begin
          tick1();
          chk("R3 decrement", cnt_rd, s - k);
          chk("R4 no early irq", irq, 0);
          idle();
          chk("R3 hold", cnt_rd, s - k);
        end
        expect_wrap("R4 first underflow");
        for (int p = 0; p < 2; p++) begin
          for (int j = 1; j <= r; j++) begin
            tick1();
            chk("R5 reload count", cnt_rd, r - j);
            chk("R5 no irq", irq, 0);
          end
          expect_wrap("R5 period end");
        end
      end
    end

    // R7: stop, ticks ignored (cnt = ONES, reload 3)
    swen(1'b0);
    for (int i = 0; i < 3; i++) begin
      tick1();
      chk("R7 cnt held", cnt_rd, ONES);
      chk("R7 ff held", ff_out, exp_ff);
      chk("R7 no irq", irq, 0);
    end
    // R7: disable and trigger in one cycle
    en_wr = 1'b1; en_wdata = 1'b0; ext_start = 1'b1;
    idle();
    en_wr = 1'b0; ext_start = 1'b0;
    tick1();
    chk("R7 disable wins ff", ff_out, exp_ff);
    chk("R7 disable wins cnt", cnt_rd, ONES);

    // R2: external start
    wcnt(W'(1));
    pulse_ext();
    tick1();
    exp_ff = ~exp_ff;
    chk("R2 ext start ff", ff_out, exp_ff);
    chk("R2 ext start cnt", cnt_rd, 1);
    tick1();
    chk("R3 ext dec", cnt_rd, 0);

    // R8: write while running ignored
    wcnt(W'(9));
    chk("R8 ignored", cnt_rd, 0);
    expect_wrap("R4 after ignored write");
    tick1();
    chk("R5 reload 3", cnt_rd, 2);

    // R10: enable requests while running
    swen(1'b1);
    pulse_ext();
    tick1();
    chk("R10 no retoggle", ff_out, exp_ff);
    chk("R10 no restart", cnt_rd, 1);

    // R9: reload change mid period
    wrld(W'(1));
    tick1();
    chk("R9 old period", cnt_rd, 0);
    expect_wrap("R9 old period end");
    tick1();
    chk("R9 new reload", cnt_rd, 0);
    wrld(W'(3));
    expect_wrap("R9 period with 1");
    tick1();
    chk("R9 reload 3 next", cnt_rd, 2);

    // R2: tick in the same cycle as the enable write
    swen(1'b0);
    wcnt(W'(2));
    en_wr = 1'b1; en_wdata = 1'b1; tick = 1'b1;
    idle();
    en_wr = 1'b0; tick = 1'b0;
    chk("R2 same-cycle tick ff", ff_out, exp_ff);
    chk("R2 same-cycle tick cnt", cnt_rd, 2);
    tick1();
    exp_ff = ~exp_ff;
    chk("R2 later tick ff", ff_out, exp_ff);
    chk("R2 later tick cnt", cnt_rd, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule